// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the time of day and the calendar date as packed binary-coded decimal fields. The fields are seconds, minutes, hours (24-hour), day of month, weekday, month and a two-digit year. A single-cycle `tick` pulse, produced elsewhere once per second, advances the seconds field. Each field carries into the next one following the rules of the calendar. Month length comes from a per-month table, and February gains a day in years divisible by four.

A synchronous load port presets every field in one clock cycle, and every field is presented as a parallel output. The block is meant to sit behind a slow tick source. Any host logic that wants to read or set the time uses the output buses and the load port directly.

Reset is asserted asynchronously and active low. Its release is synchronised to `clk` through two flops, so the counter leaves its reset state on the second rising edge after `rst_n` goes high.

Top module: `bcd_calendar_counter`

## Requirements
- R1: While reset is held and after it is released, the outputs read hour 00, minute 00, second 00, day 01, month 01, year 00 and weekday 0, until the first load or tick.
- R2: Each tick raises the seconds by one in BCD. A low digit of 9 becomes 0 and the high digit rises by one, so 09 becomes 10.
- R3: A tick at second 59 sets the seconds to 00 and raises the minutes by one. At minute 59 the minutes go to 00 and the hours rise by one.
- R4: A tick at 23:59:59 sets the time to 00:00:00 and advances both the day of month and the weekday by one.
- R5: The weekday (3 bits, values 0 to 6) advances from 6 to 0.
- R6: Months 1 to 12 last 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 days. When the day advances past the last day, the day becomes 01 and the month rises by one. This includes BCD month 09 going to 10.
- R7: When the year value is divisible by four (00 counts), February has 29 days. Otherwise February 28 is followed by March 01.
- R8: Month 12 advances to 01 and raises the year by one. Year 99 advances to 00.
- R9: While `load` is high, all seven fields take the load-bus values at the next edge. A coincident tick is then ignored.
- R10: With neither `load` nor `tick` high, every field holds its value, whatever the load buses carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse: advance one second |
| load | input | 1 | Write all load-bus fields this cycle |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD 00-23 |
| ld_day | input | 8 | Day of month to load, BCD |
| ld_wday | input | 3 | Weekday to load, 0-6 |
| ld_month | input | 8 | Month to load, BCD 01-12 |
| ld_year | input | 8 | Year to load, BCD 00-99 |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours, BCD |
| day | output | 8 | Day of month, BCD |
| wday | output | 3 | Weekday |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year, BCD |

## Verification
The bench presets a time through the load port just before a boundary and then issues a single tick. This isolates one carry at a time:
- a units-digit carry
- a minute-to-hour ripple
- a midnight rollover that also wraps the weekday
- the end of a 30-day month and of a 31-day month
- the BCD month step from 09 to 10
- February in a leap year, in a common year and in year 00
- the New Year rollover, both from 99 and from a plain decade step

Each case distinguishes one row of the month table or one carry link from its neighbours. A load that coincides with a tick separates load priority from tick handling. Idle cycles with changing load buses separate hold behaviour from leakage of the load buses into the fields.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;
  localparam int DIGIT_W = 4;
  localparam int FIELD_W = 2 * DIGIT_W;
  localparam int WDAY_W  = 3;
  localparam int WDAY_LAST = 6;

  typedef logic [FIELD_W-1:0] bcd_t;
  typedef logic [WDAY_W-1:0]  wday_t;

  typedef struct packed {
    bcd_t  sec;
    bcd_t  min;
    bcd_t  hour;
    bcd_t  day;
    wday_t wday;
    bcd_t  month;
    bcd_t  year;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                 day: 8'h01, wday: 3'd0, month: 8'h01,
                                 year: 8'h00};

  // two BCD digits to a binary value 0..99
  function automatic logic [6:0] bcd_to_bin(input bcd_t v);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = {3'b000, v[FIELD_W-1:DIGIT_W]};
    units = {3'b000, v[DIGIT_W-1:0]};
    return (tens << 3) + (tens << 1) + units;
  endfunction
endpackage

// File: rtl/bcd_pair_counter.sv
`timescale 1ns/1ps
module bcd_pair_counter #(
  parameter int DIGIT_W = 4,
  localparam int FW = 2 * DIGIT_W
) (
  input  logic          en,
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] limit,
  input  logic [FW-1:0] wrap_val,
  output logic [FW-1:0] nxt,
  output logic          carry
);
  localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);

  logic at_lim;

  always_comb begin
    at_lim = (cur >= limit);
    carry  = en & at_lim;
    if (!en) begin
      nxt = cur;
    end else if (at_lim) begin
      nxt = wrap_val;
    end else if (cur[DIGIT_W-1:0] >= NINE) begin
      nxt = {cur[FW-1:DIGIT_W] + DIGIT_W'(1), {DIGIT_W{1'b0}}};
    end else begin
      nxt = cur + FW'(1);
    end
  end
endmodule

// File: rtl/bcd_month_len.sv
`timescale 1ns/1ps
module bcd_month_len
  import bcd_cal_pkg::*;
(
  input  bcd_t month,
  input  bcd_t year,
  output bcd_t last_day
);
  logic [6:0] mon_bin;
  logic [6:0] yr_bin;
  logic       leap;

  always_comb begin
    mon_bin = bcd_to_bin(month);
    yr_bin  = bcd_to_bin(year);
    leap    = (yr_bin[1:0] == 2'b00);
    case (mon_bin)
      7'd2:                     last_day = leap ? 8'h29 : 8'h28;
      7'd4, 7'd6, 7'd9, 7'd11:  last_day = 8'h30;
      default:                  last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rst_sync_n.sv
`timescale 1ns/1ps
module rst_sync_n #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bcd_calendar_counter.sv
`timescale 1ns/1ps
module bcd_calendar_counter
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_day,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] day,
  output logic [2:0] wday,
  output logic [7:0] month,
  output logic [7:0] year
);
  logic rst_int_n;
  cal_t cal_q, cal_d, cal_adv, cal_ld;
  bcd_t month_last;
  logic sec_c, min_c, hour_c, day_c, month_c, year_c;

  rst_sync_n #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync(rst_int_n)
  );

  bcd_month_len u_mlen (
    .month(cal_q.month), .year(cal_q.year), .last_day(month_last)
  );

  bcd_pair_counter #(.DIGIT_W(DIGIT_W)) u_sec (
    .en(tick), .cur(cal_q.sec), .limit(8'h59), .wrap_val(8'h00),
    .nxt(cal_adv.sec), .carry(sec_c)
  );
  bcd_pair_counter #(.DIGIT_W(DIGIT_W)) u_min (
    .en(sec_c), .cur(cal_q.min), .limit(8'h59), .wrap_val(8'h00),
    .nxt(cal_adv.min), .carry(min_c)
  );
  bcd_pair_counter #(.DIGIT_W(DIGIT_W)) u_hour (
    .en(min_c), .cur(cal_q.hour), .limit(8'h23), .wrap_val(8'h00),
    .nxt(cal_adv.hour), .carry(hour_c)
  );
  bcd_pair_counter #(.DIGIT_W(DIGIT_W)) u_day (
    .en(hour_c), .cur(cal_q.day), .limit(month_last), .wrap_val(8'h01),
    .nxt(cal_adv.day), .carry(day_c)
  );
  bcd_pair_counter #(.DIGIT_W(DIGIT_W)) u_month (
    .en(day_c), .cur(cal_q.month), .limit(8'h12), .wrap_val(8'h01),
    .nxt(cal_adv.month), .carry(month_c)
  );
  bcd_pair_counter #(.DIGIT_W(DIGIT_W)) u_year (
    .en(month_c), .cur(cal_q.year), .limit(8'h99), .wrap_val(8'h00),
    .nxt(cal_adv.year), .carry(year_c)
  );

  // weekday follows the day carry
  always_comb begin
    if (!hour_c)                                 cal_adv.wday = cal_q.wday;
    else if (cal_q.wday >= WDAY_W'(WDAY_LAST))   cal_adv.wday = '0;
    else                                         cal_adv.wday = cal_q.wday + WDAY_W'(1);
  end

  always_comb begin
    cal_ld = '{sec: ld_sec, min: ld_min, hour: ld_hour, day: ld_day,
               wday: ld_wday, month: ld_month, year: ld_year};
    if (load) cal_d = cal_ld;
    else      cal_d = cal_adv;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       cal_q <= CAL_RESET;
    else if (load | tick) cal_q <= cal_d;
  end

  assign sec   = cal_q.sec;
  assign min   = cal_q.min;
  assign hour  = cal_q.hour;
  assign day   = cal_q.day;
  assign wday  = cal_q.wday;
  assign month = cal_q.month;
  assign year  = cal_q.year;

  // the year carry leaves the block unused; kept visible for the checker
  logic year_wrap;
  assign year_wrap = year_c;
endmodule

// File: rtl/bcd_calendar_chk.sv
`timescale 1ns/1ps
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] day,
  input logic [2:0] wday,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       year_wrap
);
  // R2
  sec_digit_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9) && (sec[7:4] <= 4'd5));

  // R5
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wday <= 3'd6);

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && sec == 8'h59) |=> (sec == 8'h00));

  // R4
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && sec == 8'h59 && min == 8'h59 && hour == 8'h23)
      |=> (hour == 8'h00) && (day != $past(day)));

  // R8
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && year_wrap) |=> (month == 8'h01));

  // R9
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec == $past(ld_sec)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
                          $stable(day) && $stable(wday) && $stable(month) &&
                          $stable(year)));
endmodule

bind bcd_calendar_counter bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .ld_sec(ld_sec),
  .sec(sec), .min(min), .hour(hour), .day(day), .wday(wday),
  .month(month), .year(year), .year_wrap(year_wrap)
);

// File: tb/bcd_calendar_counter_test.sv
`timescale 1ns/1ps
module bcd_calendar_counter_test;
  logic       clk = 1'b0;
  logic       rst_n, tick, load;
  logic [7:0] ld_sec, ld_min, ld_hour, ld_day, ld_month, ld_year;
  logic [2:0] ld_wday;
  logic [7:0] sec, min, hour, day, month, year;
  logic [2:0] wday;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_calendar_counter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_day(ld_day),
    .ld_wday(ld_wday), .ld_month(ld_month), .ld_year(ld_year),
    .sec(sec), .min(min), .hour(hour), .day(day), .wday(wday),
    .month(month), .year(year)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_all(input string tag, input logic [7:0] h, m, s, d,
                            input logic [2:0] w, input logic [7:0] mo, y);
    chk({tag, " hour"}, hour, h);
    chk({tag, " min"}, min, m);
    chk({tag, " sec"}, sec, s);
    chk({tag, " day"}, day, d);
    chk({tag, " wday"}, {5'b0, wday}, {5'b0, w});
    chk({tag, " month"}, month, mo);
    chk({tag, " year"}, year, y);
  endtask

  task automatic put(input logic [7:0] h, m, s, d, input logic [2:0] w,
                     input logic [7:0] mo, y, input logic with_tick);
    @(negedge clk);
    ld_hour = h; ld_min = m; ld_sec = s; ld_day = d;
    ld_wday = w; ld_month = mo; ld_year = y;
    load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    expect_all("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 3'd0, 8'h01, 8'h00);
  endtask

  task automatic t_digit();
    put(8'h10, 8'h20, 8'h08, 8'h05, 3'd2, 8'h03, 8'h11, 1'b0);
    step(); chk("R2 sec 08->09", sec, 8'h09);
    step(); chk("R2 sec 09->10", sec, 8'h10);
    chk("R2 min unchanged", min, 8'h20);
  endtask

  task automatic t_min_hour();
    put(8'h12, 8'h59, 8'h59, 8'h05, 3'd2, 8'h03, 8'h11, 1'b0);
    step();
    expect_all("R3 12:59:59", 8'h13, 8'h00, 8'h00, 8'h05, 3'd2, 8'h03, 8'h11);
    put(8'h09, 8'h19, 8'h59, 8'h05, 3'd2, 8'h03, 8'h11, 1'b0);
    step(); chk("R3 min 19->20", min, 8'h20); chk("R3 hour 09 held", hour, 8'h09);
  endtask

  task automatic t_midnight();
    put(8'h23, 8'h59, 8'h59, 8'h15, 3'd6, 8'h06, 8'h10, 1'b0);
    step();
    expect_all("R4 R5 midnight wday 6", 8'h00, 8'h00, 8'h00, 8'h16, 3'd0, 8'h06, 8'h10);
    put(8'h23, 8'h59, 8'h59, 8'h09, 3'd3, 8'h06, 8'h10, 1'b0);
    step(); chk("R4 day 09->10", day, 8'h10); chk("R5 wday 3->4", {5'b0, wday}, 8'h04);
  endtask

  task automatic t_month_len();
    put(8'h23, 8'h59, 8'h59, 8'h30, 3'd1, 8'h04, 8'h10, 1'b0);
    step(); chk("R6 apr30 day", day, 8'h01); chk("R6 apr30 month", month, 8'h05);
    put(8'h23, 8'h59, 8'h59, 8'h30, 3'd1, 8'h05, 8'h10, 1'b0);
    step(); chk("R6 may30 day", day, 8'h31); chk("R6 may30 month", month, 8'h05);
    put(8'h23, 8'h59, 8'h59, 8'h31, 3'd1, 8'h01, 8'h10, 1'b0);
    step(); chk("R6 jan31 month", month, 8'h02);
    put(8'h23, 8'h59, 8'h59, 8'h30, 3'd1, 8'h09, 8'h10, 1'b0);
    step(); chk("R6 sep30 day", day, 8'h01); chk("R6 sep30 month", month, 8'h10);
    put(8'h23, 8'h59, 8'h59, 8'h31, 3'd1, 8'h10, 8'h10, 1'b0);
    step(); chk("R6 oct31 month", month, 8'h11);
    put(8'h23, 8'h59, 8'h59, 8'h30, 3'd1, 8'h11, 8'h10, 1'b0);
    step(); chk("R6 nov30 month", month, 8'h12);
  endtask

  task automatic t_leap();
    put(8'h23, 8'h59, 8'h59, 8'h28, 3'd0, 8'h02, 8'h24, 1'b0);
    step(); chk("R7 y24 feb28 day", day, 8'h29); chk("R7 y24 feb28 month", month, 8'h02);
    put(8'h23, 8'h59, 8'h59, 8'h29, 3'd0, 8'h02, 8'h24, 1'b0);
    step(); chk("R7 y24 feb29 day", day, 8'h01); chk("R7 y24 feb29 month", month, 8'h03);
    put(8'h23, 8'h59, 8'h59, 8'h28, 3'd0, 8'h02, 8'h23, 1'b0);
    step(); chk("R7 y23 feb28 day", day, 8'h01); chk("R7 y23 feb28 month", month, 8'h03);
    put(8'h23, 8'h59, 8'h59, 8'h28, 3'd0, 8'h02, 8'h00, 1'b0);
    step(); chk("R7 y00 feb28 day", day, 8'h29);
    put(8'h23, 8'h59, 8'h59, 8'h28, 3'd0, 8'h02, 8'h18, 1'b0);
    step(); chk("R7 y18 feb28 month", month, 8'h03);
  endtask

  task automatic t_year();
    put(8'h23, 8'h59, 8'h59, 8'h31, 3'd5, 8'h12, 8'h99, 1'b0);
    step();
    expect_all("R8 y99 new year", 8'h00, 8'h00, 8'h00, 8'h01, 3'd6, 8'h01, 8'h00);
    put(8'h23, 8'h59, 8'h59, 8'h31, 3'd5, 8'h12, 8'h19, 1'b0);
    step(); chk("R8 y19->20", year, 8'h20); chk("R8 month 12->01", month, 8'h01);
  endtask

  task automatic t_load();
    put(8'h07, 8'h45, 8'h30, 8'h22, 3'd4, 8'h08, 8'h55, 1'b1);
    expect_all("R9 load with tick", 8'h07, 8'h45, 8'h30, 8'h22, 3'd4, 8'h08, 8'h55);
  endtask

  task automatic t_hold();
    @(negedge clk);
    ld_hour = 8'h11; ld_min = 8'h11; ld_sec = 8'h11; ld_day = 8'h11;
    ld_wday = 3'd1; ld_month = 8'h11; ld_year = 8'h11;
    repeat (4) @(negedge clk);
    expect_all("R10 idle hold", 8'h07, 8'h45, 8'h30, 8'h22, 3'd4, 8'h08, 8'h55);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; load = 1'b0;
    ld_sec = '0; ld_min = '0; ld_hour = '0; ld_day = '0;
    ld_wday = '0; ld_month = '0; ld_year = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_digit();
    t_min_hour();
    t_midnight();
    t_month_len();
    t_leap();
    t_year();
    t_load();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule